// File: doc/BRIEF.md
# Multiplexed external memory bus controller

This block connects an internal request port to an asynchronous SRAM-style external bus. The external bus shares one 8-bit lane between the low address byte and the data byte. A one-cycle address latch enable (ALE) marks the cycle in which the lane carries the address, so an external latch can hold it. The high address byte has its own output, and the read and write strobes are active low. The address space splits into a lower and an upper sector at a programmable boundary on the high address byte. Each sector has its own 2-bit wait-state code, so a slow and a fast memory can share the bus.

The request side is valid/ready. A requester raises `req_valid` with address, direction and write data, and holds all of them stable until it sees `req_ready` high at a clock edge. `req_ready` does not depend on `req_valid`. It is high when the bus is idle, in the final strobe cycle of an access that has no recovery cycle, and in a recovery cycle. A request accepted at the end of an access gets its address cycle in the trailing period straight away, so back-to-back accesses lose no cycle. The response side has no back-pressure. `rsp_valid` pulses for one cycle per accepted request, and for reads `rsp_rdata` carries the sampled byte.

When the controller does not drive the lane, a bus-keeper can hold the last lane level, and pull-ups can be enabled. Both controls are plain configuration inputs.

Top module: `xmb_mux_ctrl`

## Requirements
- R1: After reset `req_ready`=1, `bus_ale`=0, `bus_rd_n`=1, `bus_wr_n`=1, `bus_ad_oe`=0 and `rsp_valid`=0. `req_ready` is high only when idle, in the last strobe cycle of an access without recovery, or in a recovery cycle. A request is accepted on a clock edge where `req_valid` and `req_ready` are both high.
- R2: The cycle after acceptance is the address cycle. In that cycle `bus_ale`=1 for exactly one cycle, the lane is driven (`bus_ad_oe`=1) with address bits [7:0], and `bus_addr_hi` carries address bits [15:8]. `bus_addr_hi` keeps that value through the strobe, and the strobe starts in the very next cycle.
- R3: The strobe lasts for a number of consecutive cycles set by the sector's wait code: 00 gives 2 cycles, 01 gives 3, 10 gives 4 and 11 gives 4.
- R4: The access uses the upper-sector code (`cfg_hi_wait`) when address bits [15:8] are greater than or equal to `cfg_bound`. Otherwise it uses `cfg_lo_wait`. The codes and the boundary are sampled at acceptance, so a later change has no effect on an access already accepted.
- R5: For a write, `bus_wr_n`=0 for the whole strobe, and the lane is driven with the write data during every strobe cycle.
- R6: For a read, `bus_rd_n`=0 for the whole strobe and the lane is released (`bus_ad_oe`=0). `rsp_rdata` returns the value of `bus_ad_i` at the end of the last strobe cycle.
- R7: `rsp_valid` is high for exactly one cycle per request: the cycle right after the last strobe cycle.
- R8: If a request is waiting (`req_valid`=1) in the cycle where `req_ready` ends an access, the following trailing cycle is that request's address cycle with ALE high. Otherwise ALE stays low in the trailing cycle.
- R9: Code 11 adds one recovery cycle after the strobe. In that cycle there is no ALE and no strobe, so the next address cycle comes at the earliest two cycles after the last strobe cycle.
- R10: `bus_rd_n` and `bus_wr_n` are never low in the same cycle.
- R11: While the lane is released, `bus_keep_on` equals `cfg_keep_en`, and it is 0 while the lane is driven. While released, `bus_ad_o` shows the lane level of the previous cycle: the controller's driven value, or `bus_ad_i` during a read strobe.
- R12: `bus_pull_on` = `cfg_pull_en` AND the lane is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request can be accepted this cycle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | 16 | Byte address |
| req_wdata | input | 8 | Write data |
| rsp_valid | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | 8 | Read data, valid with `rsp_valid` on reads |
| cfg_lo_wait | input | 2 | Wait code for the lower sector |
| cfg_hi_wait | input | 2 | Wait code for the upper sector |
| cfg_bound | input | 8 | First high-address value of the upper sector |
| cfg_keep_en | input | 1 | Bus-keeper enable |
| cfg_pull_en | input | 1 | Lane pull-up enable |
| bus_ale | output | 1 | Address latch enable, active high |
| bus_addr_hi | output | 8 | High address byte |
| bus_ad_o | output | 8 | Shared lane output value |
| bus_ad_oe | output | 1 | Shared lane strong drive enable |
| bus_ad_i | input | 8 | Shared lane input value |
| bus_keep_on | output | 1 | Keeper holding `bus_ad_o` weakly on the lane |
| bus_pull_on | output | 1 | Lane pull-ups active |
| bus_rd_n | output | 1 | Read strobe, active low |
| bus_wr_n | output | 1 | Write strobe, active low |

## Verification
The hardest situation to reach is the trailing cycle that holds the next access's ALE. To get there, a new request must be waiting in exactly the cycle where the previous access grants `req_ready`. With code 11 that cycle is the recovery cycle, not the last strobe cycle. The bench reaches this by issuing each new request in the cycle after the previous one is accepted, for every pair of lower and upper codes and several boundary values. It then repeats the same patterns with idle gaps, so the trailing cycle is seen both with and without ALE. To show that the wait code is sampled at acceptance, one sequence changes the code right after a request is accepted.

// File: rtl/xmb_pkg.sv
`timescale 1ns/1ps
package xmb_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ADDR = 2'd1,
    ST_STRB = 2'd2,
    ST_RECV = 2'd3
  } xmb_state_e;

  localparam int unsigned LEN_W = 3;

  typedef struct packed {
    logic [LEN_W-1:0] strb_len;
    logic             recov;
  } xmb_timing_t;

  // Wait code to strobe length and recovery flag
  function automatic xmb_timing_t xmb_decode(input logic [1:0] code);
    xmb_timing_t t;
    t.recov = (code == 2'b11);
    unique case (code)
      2'b00:   t.strb_len = LEN_W'(2);
      2'b01:   t.strb_len = LEN_W'(3);
      default: t.strb_len = LEN_W'(4);
    endcase
    return t;
  endfunction

endpackage

// File: rtl/xmb_sector_sel.sv
`timescale 1ns/1ps
module xmb_sector_sel
  import xmb_pkg::*;
#(
  parameter int unsigned HI_W = 8
) (
  input  logic [HI_W-1:0] addr_hi,
  input  logic [HI_W-1:0] bound,
  input  logic [1:0]      lo_code,
  input  logic [1:0]      hi_code,
  output xmb_timing_t     timing
);
  logic       upper;
  logic [1:0] code;

  always_comb begin
    upper  = (addr_hi >= bound);
    code   = upper ? hi_code : lo_code;
    timing = xmb_decode(code);
  end

endmodule

// File: rtl/xmb_seq.sv
`timescale 1ns/1ps
module xmb_seq
  import xmb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  input  xmb_timing_t       acc_timing,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              req_ready,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              ale,
  output logic              rd_n,
  output logic              wr_n,
  output logic [HI_W-1:0]   addr_hi,
  output logic              drv_en,
  output logic [DATA_W-1:0] drv_val
);
  xmb_state_e        state_q, state_d;
  logic [LEN_W-1:0]  cnt_q;
  logic [LEN_W-1:0]  len_q;
  logic              recov_q;
  logic              write_q;
  logic [ADDR_W-1:0] addr_q;
  logic [DATA_W-1:0] wdata_q;
  logic              rsp_q;
  logic [DATA_W-1:0] rdata_q;
  logic              last_strb;
  logic              accept;

  always_comb begin
    last_strb = (state_q == ST_STRB) && (cnt_q == len_q - LEN_W'(1));
    req_ready = (state_q == ST_IDLE) || (state_q == ST_RECV) ||
                (last_strb && !recov_q);
    accept    = req_valid && req_ready;
  end

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (accept) state_d = ST_ADDR;
      ST_ADDR: state_d = ST_STRB;
      ST_STRB: begin
        if (last_strb) begin
          if (recov_q)     state_d = ST_RECV;
          else if (accept) state_d = ST_ADDR;
          else             state_d = ST_IDLE;
        end
      end
      ST_RECV: state_d = accept ? ST_ADDR : ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      len_q   <= LEN_W'(2);
      recov_q <= 1'b0;
      write_q <= 1'b0;
      addr_q  <= '0;
      wdata_q <= '0;
      rsp_q   <= 1'b0;
      rdata_q <= '0;
    end else begin
      state_q <= state_d;
      if (state_q == ST_STRB && !last_strb) cnt_q <= cnt_q + LEN_W'(1);
      else                                  cnt_q <= '0;
      if (accept) begin
        len_q   <= acc_timing.strb_len;
        recov_q <= acc_timing.recov;
        write_q <= req_write;
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      rsp_q <= last_strb;
      if (last_strb && !write_q) rdata_q <= bus_ad_i;
    end
  end

  always_comb begin
    ale       = (state_q == ST_ADDR);
    rd_n      = !((state_q == ST_STRB) && !write_q);
    wr_n      = !((state_q == ST_STRB) && write_q);
    addr_hi   = addr_q[ADDR_W-1 -: HI_W];
    drv_en    = (state_q == ST_ADDR) || ((state_q == ST_STRB) && write_q);
    drv_val   = (state_q == ST_ADDR) ? addr_q[DATA_W-1:0] : wdata_q;
    rsp_valid = rsp_q;
    rsp_rdata = rdata_q;
  end

  AST_STROBE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(!rd_n && !wr_n)); // R10
  AST_ALE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ale |=> (!ale && (!rd_n || !wr_n))); // R2
  AST_NOT_READY_IN_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    ale |-> !req_ready); // R1
  AST_RSP_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> ($past(!rd_n || !wr_n) && rd_n && wr_n)); // R7
  AST_RECOVERY_GAP: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_RECV) |-> ($past(state_q == ST_STRB) && !ale)); // R9

endmodule

// File: rtl/xmb_lane.sv
`timescale 1ns/1ps
module xmb_lane #(
  parameter int unsigned DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              drv_en,
  input  logic [DATA_W-1:0] drv_val,
  input  logic              rd_active,
  input  logic [DATA_W-1:0] bus_ad_i,
  input  logic              keep_en,
  input  logic              pull_en,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe,
  output logic              bus_keep_on,
  output logic              bus_pull_on
);
  logic [DATA_W-1:0] keep_q;

  for (genvar b = 0; b < DATA_W; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)         keep_q[b] <= 1'b0;
      else if (drv_en)    keep_q[b] <= drv_val[b];
      else if (rd_active) keep_q[b] <= bus_ad_i[b];
    end
    assign bus_ad_o[b] = drv_en ? drv_val[b] : keep_q[b];
  end

  always_comb begin
    bus_ad_oe   = drv_en;
    bus_keep_on = keep_en && !drv_en;
    bus_pull_on = pull_en && !drv_en;
  end

  AST_READ_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
    rd_active |-> !bus_ad_oe); // R6
  AST_KEEP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_keep_on && $past(bus_keep_on) && $past(!rd_active)) |-> $stable(bus_ad_o)); // R11
  AST_PULL_OFF_DRIVEN: assert property (@(posedge clk) disable iff (!rst_n)
    bus_ad_oe |-> !bus_pull_on); // R12

endmodule

// File: rtl/xmb_mux_ctrl.sv
`timescale 1ns/1ps
module xmb_mux_ctrl
  import xmb_pkg::*;
#(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned DATA_W = 8,
  localparam int unsigned HI_W  = ADDR_W - DATA_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  input  logic [1:0]        cfg_lo_wait,
  input  logic [1:0]        cfg_hi_wait,
  input  logic [HI_W-1:0]   cfg_bound,
  input  logic              cfg_keep_en,
  input  logic              cfg_pull_en,
  output logic              bus_ale,
  output logic [HI_W-1:0]   bus_addr_hi,
  output logic [DATA_W-1:0] bus_ad_o,
  output logic              bus_ad_oe,
  input  logic [DATA_W-1:0] bus_ad_i,
  output logic              bus_keep_on,
  output logic              bus_pull_on,
  output logic              bus_rd_n,
  output logic              bus_wr_n
);
  xmb_timing_t       acc_timing;
  logic              drv_en;
  logic [DATA_W-1:0] drv_val;

  xmb_sector_sel #(.HI_W(HI_W)) i_sector (
    .addr_hi (req_addr[ADDR_W-1 -: HI_W]),
    .bound   (cfg_bound),
    .lo_code (cfg_lo_wait),
    .hi_code (cfg_hi_wait),
    .timing  (acc_timing)
  );

  xmb_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_seq (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_write  (req_write),
    .req_addr   (req_addr),
    .req_wdata  (req_wdata),
    .acc_timing (acc_timing),
    .bus_ad_i   (bus_ad_i),
    .req_ready  (req_ready),
    .rsp_valid  (rsp_valid),
    .rsp_rdata  (rsp_rdata),
    .ale        (bus_ale),
    .rd_n       (bus_rd_n),
    .wr_n       (bus_wr_n),
    .addr_hi    (bus_addr_hi),
    .drv_en     (drv_en),
    .drv_val    (drv_val)
  );

  xmb_lane #(.DATA_W(DATA_W)) i_lane (
    .clk         (clk),
    .rst_n       (rst_n),
    .drv_en      (drv_en),
    .drv_val     (drv_val),
    .rd_active   (!bus_rd_n),
    .bus_ad_i    (bus_ad_i),
    .keep_en     (cfg_keep_en),
    .pull_en     (cfg_pull_en),
    .bus_ad_o    (bus_ad_o),
    .bus_ad_oe   (bus_ad_oe),
    .bus_keep_on (bus_keep_on),
    .bus_pull_on (bus_pull_on)
  );

  AST_WRITE_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr_n |-> bus_ad_oe); // R5

endmodule

// File: tb/test_xmb_mux_ctrl.sv
`timescale 1ns/1ps
module test_xmb_mux_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [15:0] req_addr = '0;
  logic [7:0]  req_wdata = '0;
  logic        req_ready, rsp_valid;
  logic [7:0]  rsp_rdata;
  logic [1:0]  cfg_lo_wait = 2'd0, cfg_hi_wait = 2'd0;
  logic [7:0]  cfg_bound = 8'h80;
  logic        cfg_keep_en = 1'b0, cfg_pull_en = 1'b0;
  logic        bus_ale, bus_ad_oe, bus_keep_on, bus_pull_on, bus_rd_n, bus_wr_n;
  logic [7:0]  bus_addr_hi, bus_ad_o;
  logic [7:0]  bus_ad_i = '0;

  always #2.5 clk = ~clk;

  xmb_mux_ctrl i_xmb_mux_ctrl (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_write(req_write), .req_addr(req_addr), .req_wdata(req_wdata),
    .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .cfg_lo_wait(cfg_lo_wait), .cfg_hi_wait(cfg_hi_wait), .cfg_bound(cfg_bound),
    .cfg_keep_en(cfg_keep_en), .cfg_pull_en(cfg_pull_en),
    .bus_ale(bus_ale), .bus_addr_hi(bus_addr_hi), .bus_ad_o(bus_ad_o),
    .bus_ad_oe(bus_ad_oe), .bus_ad_i(bus_ad_i), .bus_keep_on(bus_keep_on),
    .bus_pull_on(bus_pull_on), .bus_rd_n(bus_rd_n), .bus_wr_n(bus_wr_n)
  );

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  // expected queue of issued requests
  localparam int QN = 512;
  logic [15:0] q_addr [QN];
  logic [7:0]  q_dat  [QN];
  bit          q_wr   [QN];
  int          q_len  [QN];
  bit          q_rec  [QN];
  int q_n = 0, a_idx = 0, r_idx = 0;

  task automatic send(input bit wr, input logic [15:0] a, input logic [7:0] d);
    logic [1:0] code;
    code = (a[15:8] >= cfg_bound) ? cfg_hi_wait : cfg_lo_wait;
    q_addr[q_n] = a; q_dat[q_n] = d; q_wr[q_n] = wr;
    q_len[q_n]  = (code == 2'd0) ? 2 : (code == 2'd1) ? 3 : 4;
    q_rec[q_n]  = (code == 2'd3);
    req_valid = 1'b1; req_write = wr; req_addr = a; req_wdata = d;
    forever begin
      @(negedge clk);
      if (req_ready) break;
    end
    @(posedge clk); #1;
    req_valid = 1'b0;
    q_n++;
  endtask

  task automatic drain();
    while (r_idx != q_n) @(posedge clk);
    repeat (3) @(posedge clk);
    #1;
  endtask

  // monitor
  bit mon_on = 0;
  int cyc = 0, t4_cyc = -1, rsp_cyc = -1, cur = 0, strb_cnt = 0;
  bit t4_pend = 0, prev_st = 0, prev_ale = 0, prev_valid = 0, in_recov = 0;
  logic [7:0] last_lane = '0;

  always @(negedge clk) begin
    if (mon_on) begin
      bit st;
      cyc++;
      st = !bus_rd_n || !bus_wr_n;
      in_recov = 0;
      chk(!(!bus_rd_n && !bus_wr_n), "R10 strobes exclusive", {bus_rd_n, bus_wr_n}, 2'b11);
      chk(bus_pull_on == (cfg_pull_en && !bus_ad_oe), "R12 pull-up", bus_pull_on, cfg_pull_en && !bus_ad_oe);
      chk(bus_keep_on == (cfg_keep_en && !bus_ad_oe), "R11 keeper enable", bus_keep_on, cfg_keep_en && !bus_ad_oe);
      if (!bus_ad_oe && cfg_keep_en)
        chk(bus_ad_o == last_lane, "R11 keeper level", bus_ad_o, last_lane);
      if (bus_ad_oe) last_lane = bus_ad_o;
      else if (!bus_rd_n) last_lane = bus_ad_i;

      // end of strobe
      if (!st && prev_st) begin
        chk(strb_cnt == q_len[cur], "R3 R4 strobe length", strb_cnt, q_len[cur]);
        rsp_cyc = cyc;
        if (q_rec[cur]) begin
          in_recov = 1;
          chk(!bus_ale && req_ready, "R9 recovery cycle", {bus_ale, req_ready}, 2'b01);
          t4_cyc = cyc + 1; t4_pend = req_valid;
        end else begin
          t4_cyc = cyc; t4_pend = prev_valid;
        end
      end
      if (cyc == t4_cyc)
        chk(bus_ale == t4_pend, "R8 trailing ALE", bus_ale, t4_pend);
      chk(rsp_valid == (cyc == rsp_cyc), "R7 response pulse", rsp_valid, cyc == rsp_cyc);
      if (rsp_valid) begin
        if (!q_wr[r_idx])
          chk(rsp_rdata == pat(q_addr[r_idx]), "R6 read data", rsp_rdata, pat(q_addr[r_idx]));
        r_idx++;
      end

      if (prev_ale) chk(!bus_ale && st, "R2 ALE one cycle then strobe", {bus_ale, st}, 2'b01);
      if (bus_ale) begin
        cur = a_idx; a_idx++;
        strb_cnt = 0;
        chk(bus_ad_oe && bus_ad_o == q_addr[cur][7:0], "R2 lane address", bus_ad_o, q_addr[cur][7:0]);
        chk(bus_addr_hi == q_addr[cur][15:8], "R2 high address", bus_addr_hi, q_addr[cur][15:8]);
        chk(!req_ready, "R1 not ready in address cycle", req_ready, 0);
        bus_ad_i = pat(q_addr[cur]);
      end
      if (st) begin
        strb_cnt++;
        chk(bus_addr_hi == q_addr[cur][15:8], "R2 high address held", bus_addr_hi, q_addr[cur][15:8]);
        chk(req_ready == (strb_cnt == q_len[cur] && !q_rec[cur]), "R1 ready in strobe", req_ready,
            strb_cnt == q_len[cur] && !q_rec[cur]);
        if (!bus_wr_n) begin
          chk(q_wr[cur], "R5 write strobe on write", 0, 1);
          chk(bus_ad_oe && bus_ad_o == q_dat[cur], "R5 write data", bus_ad_o, q_dat[cur]);
        end
        if (!bus_rd_n) begin
          chk(!q_wr[cur], "R6 read strobe on read", 0, 1);
          chk(!bus_ad_oe, "R6 lane released", bus_ad_oe, 0);
        end
      end
      if (!st && !bus_ale && !in_recov)
        chk(req_ready, "R1 ready when idle", req_ready, 1);
      prev_st = st; prev_ale = bus_ale; prev_valid = req_valid;
    end
  end

  initial begin
    #(5.0 * 150000);
    n_fail++; n_chk++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    logic [7:0] bounds [4];
    bounds[0] = 8'h80; bounds[1] = 8'h01; bounds[2] = 8'h00; bounds[3] = 8'hFF;
    repeat (3) @(posedge clk);
    #1;
    chk(req_ready && !bus_ale && bus_rd_n && bus_wr_n && !bus_ad_oe && !rsp_valid,
        "R1 reset state", {req_ready, bus_ale, bus_rd_n, bus_wr_n, bus_ad_oe, rsp_valid}, 6'b101100);
    rst_n = 1'b1;
    @(posedge clk); #1;
    mon_on = 1;

    for (int b = 0; b < 4; b++) begin
      for (int lo = 0; lo < 4; lo++) begin
        for (int hi = 0; hi < 4; hi++) begin
          bit b2b;
          logic [15:0] a_lo, a_up;
          cfg_bound   = bounds[b];
          cfg_lo_wait = 2'(lo);
          cfg_hi_wait = 2'(hi);
          cfg_keep_en = 1'(hi ^ b);
          cfg_pull_en = 1'(lo);
          b2b  = 1'((lo + hi + b) % 2);
          a_lo = {bounds[b] - 8'd1, 8'(lo * 16 + hi + 3)};
          a_up = {bounds[b], 8'(hi * 16 + lo + 9)};
          send(1'b1, a_lo, 8'(a_lo[7:0] + 8'h3C));
          if (!b2b) drain();
          send(1'b0, a_up, 8'h00);
          if (!b2b) drain();
          send(1'b0, a_lo, 8'h00);
          if (!b2b) drain();
          send(1'b1, a_up, 8'(a_up[7:0] + 8'h5D));
          drain();
        end
      end
    end

    // R4: wait code sampled at acceptance, changed right after
    cfg_bound = 8'h80; cfg_lo_wait = 2'd0; cfg_hi_wait = 2'd3;
    send(1'b0, 16'h1234, 8'h00);
    cfg_lo_wait = 2'd2;
    send(1'b1, 16'h9A10, 8'h77);
    cfg_hi_wait = 2'd1;
    drain();

    mon_on = 0;
    chk(r_idx == q_n && a_idx == q_n, "R7 one response per request", r_idx, q_n);
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule